// File: doc/BRIEF.md
# Byte ALU with Carry, Auxiliary-Carry and Overflow Flags

This block is the combinational arithmetic and logic unit for an 8-bit accumulator machine. Each cycle it takes the accumulator, a second operand byte, the multiplier/divisor register, the incoming carry and auxiliary-carry flags, and an operation select. It returns a primary result byte, a secondary result byte, and a new value with a write enable for each of the carry (C), auxiliary-carry (AC) and overflow (OV) flags. The surrounding datapath writes the results and the enabled flags back to its own registers.

The primary result normally goes to the accumulator. The secondary result carries the high product byte for multiply, the remainder for divide, and the updated operand for the low-nibble exchange. For every other operation it passes the operand byte through unchanged. When a flag's enable is low, its output repeats its input (OV repeats 0), so the caller may also write it back without checking the enable.

Top module: `acc_alu`

## Requirements
- R1: Operation 0 (plain add) and operation 1 (add plus carry-in) give the low 8 bits of the sum. They set C when the unsigned sum exceeds FFh and set AC on a carry out of bit 3. Operation 0 ignores cy_in. All three flag enables are high.
- R2: For operations 0 and 1, OV is set exactly when one, and only one, of the carries out of bit 6 and bit 7 occurs. For example, 3Fh + D3h gives 12h with C=1, AC=1 and OV=0.
- R3: Operation 2 always subtracts both the operand and cy_in from the accumulator. C shows a borrow out of bit 7, AC shows a borrow out of bit 3, and OV shows signed overflow. All three enables are high.
- R4: Operation 3 adds 1 and operation 4 subtracts 1, both wrapping modulo 256. No flag enable is raised.
- R5: Operation 5 multiplies acc by breg. The low product byte goes to res and the high byte to res2. C is cleared, and OV is set when the high byte is nonzero. AC is not updated.
- R6: Operation 6 divides acc by breg, putting the quotient in res and the remainder in res2, and clears C. When breg is zero, OV is set, res is FFh and res2 repeats acc. Otherwise OV is cleared. AC is not updated.
- R7: Operation 7 is the decimal adjust. It adds 06h when the low nibble exceeds 9 or ac_in is set. It then adds 60h when the high nibble exceeds 9, cy_in is set, or the first step carried, and sets C exactly when that second correction is applied. Only C is enabled.
- R8: Operations 8 to 12 are AND, OR, XOR with the operand, complement of acc, and clear to 00h. No flag enable is raised.
- R9: Operation 13 rotates acc left one bit, operation 15 rotates it right, and operation 17 swaps its two nibbles. No flag enable is raised.
- R10: Operation 14 rotates left and operation 16 rotates right through C, treated as a ninth bit. The bit shifted out becomes C. Only C is enabled.
- R11: Operation 18 exchanges the low nibbles. res is acc with opnd's low nibble, and res2 is opnd with acc's low nibble. No flag enable is raised.
- R12: Operation codes 19 to 31 pass acc to res and opnd to res2, and raise no flag enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation select |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Second operand byte |
| breg | input | 8 | Multiplier / divisor register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| res | output | 8 | Primary result |
| res2 | output | 8 | Secondary result |
| cy_out | output | 1 | New carry flag |
| cy_we | output | 1 | Carry update enable |
| ac_out | output | 1 | New auxiliary-carry flag |
| ac_we | output | 1 | Auxiliary-carry update enable |
| ov_out | output | 1 | New overflow flag |
| ov_we | output | 1 | Overflow update enable |

## Verification
The unit has no parameters, so the bench builds it at its fixed byte width. At that width every accumulator value can be swept. A full sweep of add-with-carry against a 9-bit reference and of division by a fixed nonzero divisor therefore reaches every carry-out and remainder case. The vector table adds the corner cases: the nibble-boundary carries, signed overflow in both directions, divide by zero, and each branch of the decimal adjust.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic [4:0] op,
  input  logic [7:0] acc,
  input  logic [7:0] opnd,
  input  logic [7:0] breg,
  input  logic       cy_in,
  input  logic       ac_in,
  output logic [7:0] res,
  output logic [7:0] res2,
  output logic       cy_out,
  output logic       cy_we,
  output logic       ac_out,
  output logic       ac_we,
  output logic       ov_out,
  output logic       ov_we
);
  localparam logic [4:0] OP_ADD = 5'd0, OP_ADDC = 5'd1, OP_SUBB = 5'd2, OP_INC = 5'd3,
                         OP_DEC = 5'd4, OP_MUL = 5'd5, OP_DIV = 5'd6, OP_DA = 5'd7,
                         OP_AND = 5'd8, OP_OR = 5'd9, OP_XOR = 5'd10, OP_CPL = 5'd11,
                         OP_CLR = 5'd12, OP_RL = 5'd13, OP_RLC = 5'd14, OP_RR = 5'd15,
                         OP_RRC = 5'd16, OP_SWAP = 5'd17, OP_XCHD = 5'd18;

  logic       cin;
  logic [8:0] sum, dif, da_lo;
  logic [7:0] sum_b6, da_hi;
  logic [4:0] sum_n, dif_n;
  logic [15:0] prod;
  logic       lo_fix, hi_fix;

  assign cin    = (op == OP_ADDC) & cy_in;
  assign sum    = {1'b0, acc} + {1'b0, opnd} + 9'(cin);
  assign sum_n  = {1'b0, acc[3:0]} + {1'b0, opnd[3:0]} + 5'(cin);
  assign sum_b6 = {1'b0, acc[6:0]} + {1'b0, opnd[6:0]} + 8'(cin);
  assign dif    = {1'b0, acc} - {1'b0, opnd} - 9'(cy_in);
  assign dif_n  = {1'b0, acc[3:0]} - {1'b0, opnd[3:0]} - 5'(cy_in);
  assign prod   = acc * breg;
  assign lo_fix = (acc[3:0] > 4'd9) | ac_in;
  assign da_lo  = {1'b0, acc} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix = (da_lo[7:4] > 4'd9) | cy_in | da_lo[8];
  assign da_hi  = da_lo[7:0] + (hi_fix ? 8'h60 : 8'h00);

  always_comb begin
    res    = acc;
    res2   = opnd;
    cy_out = cy_in;
    ac_out = ac_in;
    ov_out = 1'b0;
    cy_we  = 1'b0;
    ac_we  = 1'b0;
    ov_we  = 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        res = sum[7:0]; cy_out = sum[8]; ac_out = sum_n[4]; ov_out = sum[8] ^ sum_b6[7];
        cy_we = 1'b1; ac_we = 1'b1; ov_we = 1'b1;
      end
      OP_SUBB: begin
        res = dif[7:0]; cy_out = dif[8]; ac_out = dif_n[4];
        ov_out = (acc[7] ^ opnd[7]) & (acc[7] ^ dif[7]);
        cy_we = 1'b1; ac_we = 1'b1; ov_we = 1'b1;
      end
      OP_INC: res = acc + 8'd1;
      OP_DEC: res = acc - 8'd1;
      OP_MUL: begin
        res = prod[7:0]; res2 = prod[15:8]; cy_out = 1'b0; ov_out = |prod[15:8];
        cy_we = 1'b1; ov_we = 1'b1;
      end
      OP_DIV: begin
        cy_out = 1'b0; cy_we = 1'b1; ov_we = 1'b1;
        if (breg == 8'h00) begin
          res = 8'hFF; res2 = acc; ov_out = 1'b1;
        end else begin
          res = acc / breg; res2 = acc % breg;
        end
      end
      OP_DA:   begin res = da_hi; cy_out = hi_fix; cy_we = 1'b1; end
      OP_AND:  res = acc & opnd;
      OP_OR:   res = acc | opnd;
      OP_XOR:  res = acc ^ opnd;
      OP_CPL:  res = ~acc;
      OP_CLR:  res = 8'h00;
      OP_RL:   res = {acc[6:0], acc[7]};
      OP_RR:   res = {acc[0], acc[7:1]};
      OP_RLC:  begin res = {acc[6:0], cy_in}; cy_out = acc[7]; cy_we = 1'b1; end
      OP_RRC:  begin res = {cy_in, acc[7:1]}; cy_out = acc[0]; cy_we = 1'b1; end
      OP_SWAP: res = {acc[3:0], acc[7:4]};
      OP_XCHD: begin res = {acc[7:4], opnd[3:0]}; res2 = {opnd[7:4], acc[3:0]}; end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, acc, opnd, breg, cy_in, ac_in})) begin
      if (op == OP_ADD || op == OP_ADDC)
        AST_ADD_OV_SIGN: assert (ov_out == ((acc[7] == opnd[7]) && (res[7] != acc[7]))) else $error("add OV"); // R2
      if (op == OP_SUBB)
        AST_SUBB_INVERSE: assert (8'(res + opnd + {7'd0, cy_in}) == acc) else $error("subb inverse"); // R3
      if (op == OP_INC || op == OP_DEC)
        AST_INCDEC_KEEP_CY: assert (!cy_we && cy_out == cy_in) else $error("inc/dec carry"); // R4
      if (op == OP_MUL)
        AST_MUL_OV_HIGH: assert (ov_out == (res2 != 8'h00) && !cy_out) else $error("mul flags"); // R5
      if (op == OP_DIV && breg != 8'h00)
        AST_DIV_IDENTITY: assert ((16'(res) * 16'(breg) + 16'(res2) == 16'(acc)) && (res2 < breg)) else $error("div identity"); // R6
      if (op >= OP_AND && op <= OP_CLR)
        AST_LOGIC_NO_FLAGS: assert (!cy_we && !ac_we && !ov_we) else $error("logic flags"); // R8
    end
  end
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [4:0] op;
  logic [7:0] acc, opnd, breg, res, res2;
  logic cy_in, ac_in, cy_out, cy_we, ac_out, ac_we, ov_out, ov_we;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  acc_alu u0 (.op(op), .acc(acc), .opnd(opnd), .breg(breg), .cy_in(cy_in), .ac_in(ac_in),
              .res(res), .res2(res2), .cy_out(cy_out), .cy_we(cy_we), .ac_out(ac_out),
              .ac_we(ac_we), .ov_out(ov_out), .ov_we(ov_we));

  // {op, acc, opnd, breg, cy_in, ac_in, res, res2, {cy_we,cy_out,ac_we,ac_out,ov_we,ov_out}}
  localparam int N = 31;
  localparam logic [52:0] TBL [N] = '{
    {5'd0,  8'h3F, 8'hD3, 8'h99, 1'b0, 1'b0, 8'h12, 8'hD3, 6'b111110}, // R1 R2
    {5'd0,  8'h7F, 8'h73, 8'h99, 1'b1, 1'b0, 8'hF2, 8'h73, 6'b101111}, // R1 R2 carry ignored
    {5'd1,  8'h8F, 8'hD3, 8'h99, 1'b1, 1'b0, 8'h63, 8'hD3, 6'b111111}, // R1 R2
    {5'd1,  8'hFF, 8'h00, 8'h99, 1'b1, 1'b0, 8'h00, 8'h00, 6'b111110}, // R1 R2
    {5'd2,  8'h50, 8'h4F, 8'h99, 1'b1, 1'b0, 8'h00, 8'h4F, 6'b101110}, // R3
    {5'd2,  8'h50, 8'h4F, 8'h99, 1'b0, 1'b0, 8'h01, 8'h4F, 6'b101110}, // R3
    {5'd2,  8'h00, 8'h01, 8'h99, 1'b0, 1'b0, 8'hFF, 8'h01, 6'b111110}, // R3
    {5'd2,  8'h80, 8'h01, 8'h99, 1'b0, 1'b0, 8'h7F, 8'h01, 6'b101111}, // R3
    {5'd3,  8'hFF, 8'h11, 8'h99, 1'b1, 1'b1, 8'h00, 8'h11, 6'b010100}, // R4
    {5'd4,  8'h00, 8'h22, 8'h99, 1'b0, 1'b0, 8'hFF, 8'h22, 6'b000000}, // R4
    {5'd5,  8'hFF, 8'h00, 8'hFF, 1'b1, 1'b0, 8'h01, 8'hFE, 6'b100011}, // R5
    {5'd5,  8'h10, 8'h00, 8'h0F, 1'b1, 1'b0, 8'hF0, 8'h00, 6'b100010}, // R5
    {5'd6,  8'h0F, 8'h00, 8'h04, 1'b1, 1'b0, 8'h03, 8'h03, 6'b100010}, // R6
    {5'd6,  8'h37, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 8'h37, 6'b100011}, // R6 divide by zero
    {5'd7,  8'h4C, 8'h00, 8'h99, 1'b0, 1'b0, 8'h52, 8'h00, 6'b100000}, // R7
    {5'd7,  8'h9A, 8'h00, 8'h99, 1'b0, 1'b0, 8'h00, 8'h00, 6'b110000}, // R7
    {5'd7,  8'h42, 8'h00, 8'h99, 1'b0, 1'b1, 8'h48, 8'h00, 6'b100100}, // R7
    {5'd7,  8'h15, 8'h00, 8'h99, 1'b1, 1'b0, 8'h75, 8'h00, 6'b110000}, // R7
    {5'd8,  8'h0F, 8'hAC, 8'h99, 1'b1, 1'b1, 8'h0C, 8'hAC, 6'b010100}, // R8
    {5'd9,  8'h0F, 8'hAC, 8'h99, 1'b0, 1'b0, 8'hAF, 8'hAC, 6'b000000}, // R8
    {5'd10, 8'h0F, 8'hAC, 8'h99, 1'b0, 1'b0, 8'hA3, 8'hAC, 6'b000000}, // R8
    {5'd11, 8'hAC, 8'h00, 8'h99, 1'b1, 1'b0, 8'h53, 8'h00, 6'b010000}, // R8
    {5'd12, 8'h5A, 8'h00, 8'h99, 1'b0, 1'b0, 8'h00, 8'h00, 6'b000000}, // R8
    {5'd13, 8'hF0, 8'h00, 8'h99, 1'b0, 1'b0, 8'hE1, 8'h00, 6'b000000}, // R9
    {5'd15, 8'hF0, 8'h00, 8'h99, 1'b1, 1'b0, 8'h78, 8'h00, 6'b010000}, // R9
    {5'd16, 8'hBD, 8'h00, 8'h99, 1'b0, 1'b0, 8'h5E, 8'h00, 6'b110000}, // R10
    {5'd14, 8'h3C, 8'h00, 8'h99, 1'b1, 1'b0, 8'h79, 8'h00, 6'b100000}, // R10
    {5'd14, 8'h03, 8'h00, 8'h99, 1'b0, 1'b0, 8'h06, 8'h00, 6'b100000}, // R10
    {5'd17, 8'h72, 8'h00, 8'h99, 1'b0, 1'b0, 8'h27, 8'h00, 6'b000000}, // R9
    {5'd18, 8'h5A, 8'hC3, 8'h99, 1'b0, 1'b0, 8'h53, 8'hCA, 6'b000000}, // R11
    {5'd31, 8'h44, 8'h55, 8'h99, 1'b1, 1'b1, 8'h44, 8'h55, 6'b010100}  // R12
  };
  localparam int REQ [N] = '{1,1,1,1,3,3,3,3,4,4,5,5,6,6,7,7,7,7,8,8,8,8,8,9,9,10,10,10,9,11,12};

  task automatic drive(input logic [4:0] o, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] b, input logic c, input logic h);
    @(negedge clk);
    op = o; acc = a; opnd = d; breg = b; cy_in = c; ac_in = h;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [21:0] got, input logic [21:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    op = '0; acc = '0; opnd = '0; breg = '0; cy_in = 1'b0; ac_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // first check: all-zero inputs on add give zero result and zero flags (R1)
    drive(5'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R1 idle", {res, res2, cy_we, cy_out, ac_we, ac_out, ov_we, ov_out},
          {8'h00, 8'h00, 6'b101010});
    for (int i = 0; i < N; i++) begin
      drive(TBL[i][52:48], TBL[i][47:40], TBL[i][39:32], TBL[i][31:24], TBL[i][23], TBL[i][22]);
      check($sformatf("R%0d vec%0d", REQ[i], i),
            {res, res2, cy_we, cy_out, ac_we, ac_out, ov_we, ov_out}, TBL[i][21:0]);
    end
    // R1 sweep: add-with-carry of 35h plus carry
    for (int a = 0; a < 256; a++) begin
      logic [8:0] s;
      s = 9'(a) + 9'h035 + 9'd1;
      drive(5'd1, 8'(a), 8'h35, 8'h00, 1'b1, 1'b0);
      check("R1 sweep", {res, res2, 5'd0, cy_out}, {s[7:0], 8'h35, 5'd0, s[8]});
    end
    // R6 sweep: divide by 7
    for (int a = 0; a < 256; a++) begin
      drive(5'd6, 8'(a), 8'h00, 8'h07, 1'b1, 1'b0);
      check("R6 sweep", {res, res2, 4'd0, cy_out, ov_out}, {8'(a / 7), 8'(a % 7), 6'b000000});
    end
    // R12 every unused code
    for (int o = 19; o < 32; o++) begin
      drive(5'(o), 8'hA5, 8'h3C, 8'h11, 1'b0, 1'b1);
      check("R12 unused", {res, res2, cy_we, cy_out, ac_we, ac_out, ov_we, ov_out},
            {8'hA5, 8'h3C, 6'b000100});
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule